// File: doc/BRIEF.md
# Serial Word RAM Slave Front End

This block puts a sixteen-word, sixteen-bit volatile RAM behind a four-wire serial slave port running in SPI mode 0. The host lowers chip select and sends an eight-bit instruction, most significant bit first. Each bit is sampled on a rising serial-clock edge. A WRITE instruction is followed by sixteen data bits. The word is committed to the RAM when chip select returns high. A READ instruction returns sixteen data bits. These are launched on falling clock edges, so the host can sample them on rising edges nine to twenty-four. The instruction's last bit is not decoded for a READ, which gives a shared data line one bit time to turn around.

Every other instruction byte is passed on to a separate latch-control block as a one-cycle request strobe. That block handles store, recall and protection. The serial pins are brought into the system clock domain through synchronizers, and all decoding is done on the system clock. The serial port cannot be stalled, so the request strobe has no back-pressure. The receiving block must accept a request in the cycle in which it appears. There is no other parallel data stream at this block's edge.

Top module: `spi_word_ram`

## Requirements
- R1: After reset `so_oe` and `req_valid` are low and every word reads back as zero.
- R2: The instruction byte `011aaaa1` (bits [7:5] = 011, address in bits [4:1], bit 0 = 1) followed by sixteen data bits, most significant first, stores those bits at address `aaaa`. The store takes effect when chip select rises.
- R3: The byte `111aaaax` (bit 0 ignored) reads address `aaaa`. Data bit 15 is launched on the falling edge after the eighth rising edge. Each following falling edge launches the next lower bit, so the host samples bits 15..0 on rising edges 9..24.
- R4: If chip select rises after k data bits, where 0 < k < 16, those k bits replace bits 15..16-k of the addressed word and the other bits are kept. If chip select rises after zero data bits, the word is unchanged.
- R5: Data bits beyond the sixteenth of a WRITE wrap around: bit 17 of the data phase lands in position 15 again, and so on. The word committed holds the most recent bit received for each position.
- R6: `so_oe` is low while chip select is high, and during a read up to the eighth falling edge. It goes low again at the falling edge after the twenty-fourth rising edge.
- R7: Any other instruction byte raises `req_valid` for exactly one system clock, with `req_code` equal to the byte. This includes a byte with bits [7:5] = 011 and bit 0 = 0. The RAM is not changed, and any further serial bits in that selection are ignored.
- R8: Clock edges while chip select is high are ignored. If chip select rises before the eighth instruction bit, the instruction is discarded with no RAM change and no request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than six times the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock, idles low |
| cs_n | input | 1 | Chip select, active low |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for the serial data pad |
| req_valid | output | 1 | One-cycle request strobe to the latch-control block |
| req_code | output | 8 | Instruction byte carried with the request |

## Verification
Two functions can land in the same system clock: the commit of the assembled word when chip select rises, and the arrival of a data bit that overwrites a position already filled. The bench provokes this by ending a WRITE directly after a wrapped bit twenty-eight, and by ending another after only five data bits. It then reads the word back and compares it against a model that merges each received bit into the old word position by position. A second collision is chip select rising in the middle of an instruction. There the bench confirms that no request strobe appears and that a later read returns the unchanged word.

// File: rtl/spi_wram_pkg.sv
package spi_wram_pkg;
  typedef enum logic [1:0] {PH_INS, PH_WR, PH_RD, PH_IGN} phase_t;
  localparam logic [2:0] CMD_WRITE = 3'b011;
  localparam logic [2:0] CMD_READ  = 3'b111;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_low,
  output logic cs_rise,
  output logic si_s
);
  logic [STAGES:0]   sck_p;
  logic [STAGES:0]   cs_p;
  logic [STAGES-1:0] si_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p <= '0;
      cs_p  <= '1;
      si_p  <= '0;
    end else begin
      sck_p <= {sck_p[STAGES-1:0], sck};
      cs_p  <= {cs_p[STAGES-1:0], cs_n};
      si_p  <= {si_p[STAGES-2:0], si};
    end
  end

  assign sck_rise = sck_p[STAGES-1] & ~sck_p[STAGES];
  assign sck_fall = ~sck_p[STAGES-1] & sck_p[STAGES];
  assign cs_low   = ~cs_p[STAGES-1];
  assign cs_rise  = cs_p[STAGES-1] & ~cs_p[STAGES];
  assign si_s     = si_p[STAGES-1];
endmodule

// File: rtl/spi_wram_array.sv
module spi_wram_array #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem[w] <= '0;
      else if (we && waddr == ADDR_W'(w)) mem[w] <= wdata;
    end
  end

  assign rdata = mem[raddr];

  // R2: a commit lands in the addressed word on the next clock
  p_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/spi_wram_ctrl.sv
module spi_wram_ctrl
  import spi_wram_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int INS_W  = ADDR_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              cs_low,
  input  logic              cs_rise,
  input  logic              si_s,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] raddr,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic [DATA_W-1:0] wdata,
  output logic              so,
  output logic              so_oe,
  output logic              req_valid,
  output logic [INS_W-1:0]  req_code
);
  localparam int BCNT_W = $clog2(INS_W);
  localparam int WIDX_W = $clog2(DATA_W);
  localparam int RCNT_W = $clog2(DATA_W + 1);

  phase_t              phase;
  logic [INS_W-2:0]    ins_sr;
  logic [BCNT_W-1:0]   bcnt;
  logic [ADDR_W-1:0]   addr;
  logic [DATA_W-1:0]   dbuf;
  logic [WIDX_W-1:0]   widx;
  logic                wr_any;
  logic [RCNT_W-1:0]   rcnt;
  logic [INS_W-1:0]    ins_next;
  logic [2:0]          cmd;
  logic [WIDX_W-1:0]   wpos;

  assign ins_next = {ins_sr, si_s};
  assign cmd      = ins_next[INS_W-1:INS_W-3];
  assign raddr    = ins_next[ADDR_W:1];
  assign wpos     = WIDX_W'(DATA_W - 1) - widx;

  // commit on chip-select rise keeps partial and wrapped data (R4, R5)
  assign we    = cs_rise && phase == PH_WR && wr_any;
  assign waddr = addr;
  assign wdata = dbuf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_INS;
      ins_sr    <= '0;
      bcnt      <= '0;
      addr      <= '0;
      dbuf      <= '0;
      widx      <= '0;
      wr_any    <= 1'b0;
      rcnt      <= '0;
      so        <= 1'b0;
      so_oe     <= 1'b0;
      req_valid <= 1'b0;
      req_code  <= '0;
    end else begin
      req_valid <= 1'b0;
      if (cs_rise) begin
        phase  <= PH_INS;
        ins_sr <= '0;
        bcnt   <= '0;
        widx   <= '0;
        wr_any <= 1'b0;
        rcnt   <= '0;
        so_oe  <= 1'b0;
      end else if (cs_low) begin
        unique case (phase)
          PH_INS: if (sck_rise) begin
            ins_sr <= ins_next[INS_W-2:0];
            bcnt   <= bcnt + 1'b1;
            if (bcnt == BCNT_W'(INS_W - 1)) begin
              addr <= raddr;
              dbuf <= rdata;
              if (cmd == CMD_READ) begin
                phase <= PH_RD;
              end else if (cmd == CMD_WRITE && ins_next[0]) begin
                phase <= PH_WR;
              end else begin
                phase     <= PH_IGN;
                req_valid <= 1'b1;
                req_code  <= ins_next;
              end
            end
          end
          PH_WR: if (sck_rise) begin
            dbuf[wpos] <= si_s;
            widx       <= (widx == WIDX_W'(DATA_W - 1)) ? '0 : widx + 1'b1;
            wr_any     <= 1'b1;
          end
          PH_RD: if (sck_fall) begin
            if (rcnt < RCNT_W'(DATA_W)) begin
              so    <= dbuf[DATA_W-1];
              dbuf  <= {dbuf[DATA_W-2:0], 1'b0};
              so_oe <= 1'b1;
              rcnt  <= rcnt + 1'b1;
            end else begin
              so_oe <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R7: request strobe lasts one clock
  p_req_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid);

  // R6: output stays released while deselected
  p_so_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_low && !cs_rise) |-> !so_oe);

  // R3: output turns on only at a serial falling edge
  p_so_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(so_oe) |-> $past(sck_fall));
endmodule

// File: rtl/spi_word_ram.sv
module spi_word_ram #(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck,
  input  logic       cs_n,
  input  logic       si,
  output logic       so,
  output logic       so_oe,
  output logic       req_valid,
  output logic [7:0] req_code
);
  localparam int INS_W = ADDR_W + 4;

  logic              sck_rise, sck_fall, cs_low, cs_rise, si_s;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr, mem_raddr;
  logic [DATA_W-1:0] mem_wdata, mem_rdata;
  logic [INS_W-1:0]  code;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_low(cs_low),
    .cs_rise(cs_rise), .si_s(si_s)
  );

  spi_wram_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .INS_W(INS_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .cs_low(cs_low), .cs_rise(cs_rise), .si_s(si_s), .rdata(mem_rdata),
    .raddr(mem_raddr), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .so(so), .so_oe(so_oe), .req_valid(req_valid), .req_code(code)
  );

  spi_wram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(mem_waddr),
    .wdata(mem_wdata), .raddr(mem_raddr), .rdata(mem_rdata)
  );

  assign req_code = 8'(code);

  // R4: no word is committed while the host still selects the block
  p_no_commit_selected_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !cs_low);
endmodule

// File: tb/spi_word_ram_test.sv
`timescale 1ns/1ps
module spi_word_ram_test;
  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, si = 1'b0;
  logic so, so_oe, req_valid;
  logic [7:0] req_code;

  int checks = 0, fails = 0;
  logic [15:0] model [16];
  logic [15:0] expq [$];
  int req_cnt = 0;
  logic [7:0] req_last = '0;
  logic [15:0] mon_sh = '0;
  int mon_nb = 0;

  spi_word_ram uut (.clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .so(so), .so_oe(so_oe), .req_valid(req_valid), .req_code(req_code));

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: assemble read words at host sample edges and pop expectations
  always @(posedge sck) begin
    if (so_oe) begin
      mon_sh = {mon_sh[14:0], so};
      mon_nb++;
      if (mon_nb == 16) begin
        if (expq.size() == 0) chk("R3 unexpected word", {16'h0, mon_sh}, 32'hffffffff);
        else chk("R3 read word", {16'h0, mon_sh}, {16'h0, expq.pop_front()});
        mon_nb = 0;
      end
    end
  end
  always @(posedge cs_n) mon_nb = 0;

  always @(negedge clk) if (req_valid) begin
    req_cnt++;
    req_last = req_code;
  end

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_cycle(input logic b);
    si = b; wclk(6); sck = 1'b1; wclk(6); sck = 1'b0;
  endtask

  task automatic frame(input logic [63:0] bits, input int n);
    cs_n = 1'b0; wclk(6);
    for (int i = 0; i < n; i++) bit_cycle(bits[n-1-i]);
    wclk(6); cs_n = 1'b1; wclk(10);
  endtask

  // driver for writes: updates model per R2/R4/R5
  task automatic wr(input logic [3:0] a, input logic [47:0] stream, input int n);
    logic [7:0] ins = {3'b011, a, 1'b1};
    frame(({56'h0, ins} << n) | {16'h0, stream}, 8 + n);
    for (int i = 0; i < n; i++) model[a][15 - (i % 16)] = stream[n-1-i];
  endtask

  // driver for reads: pushes expectation, checks output enable timing (R6)
  task automatic rd(input logic [3:0] a, input logic b0);
    logic [7:0] ins = {3'b111, a, b0};
    expq.push_back(model[a]);
    cs_n = 1'b0; wclk(6);
    for (int i = 0; i < 7; i++) bit_cycle(ins[7-i]);
    si = ins[0]; wclk(6); sck = 1'b1; wclk(5);
    chk("R6 so_oe before eighth fall", {31'h0, so_oe}, 32'h0);
    wclk(1); sck = 1'b0;
    for (int i = 0; i < 16; i++) bit_cycle(1'b0);
    wclk(6);
    chk("R6 so_oe released after 16 bits", {31'h0, so_oe}, 32'h0);
    cs_n = 1'b1; wclk(10);
    chk("R6 so_oe with cs high", {31'h0, so_oe}, 32'h0);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = '0;
    wclk(5); rst_n = 1'b1; wclk(5);
    chk("R1 so_oe after reset", {31'h0, so_oe}, 32'h0);
    chk("R1 req_valid after reset", {31'h0, req_valid}, 32'h0);
    for (int i = 0; i < 16; i++) rd(4'(i), 1'b1);   // R1 all words zero

    wr(4'd3, 48'h0000_0000_A5C3, 16);               // R2
    rd(4'd3, 1'b1);
    rd(4'd3, 1'b0);                                 // R3 bit 0 ignored
    wr(4'd15, 48'h0000_0000_1234, 16);              // R2
    rd(4'd15, 1'b0);

    wr(4'd3, 48'h0000_0000_0016, 5);                // R4 partial: 10110
    rd(4'd3, 1'b1);
    wr(4'd15, 48'h0, 0);                            // R4 zero data bits
    rd(4'd15, 1'b1);

    wr(4'd7, 48'h0000_0BEE_F123, 28);               // R5 wrap
    rd(4'd7, 1'b0);
    wr(4'd8, 48'h0000_5555_AAAA, 32);               // R5 two full wraps
    rd(4'd8, 1'b1);

    frame({46'h0, 8'h05, 10'h3FF}, 18);             // R7 other opcode
    chk("R7 request count", 32'(req_cnt), 32'd1);
    chk("R7 request code", {24'h0, req_last}, 32'h05);
    frame({48'h0, 8'h66, 8'hFF}, 16);               // R7 write-like with bit0 = 0
    chk("R7 request count second", 32'(req_cnt), 32'd2);
    chk("R7 request code second", {24'h0, req_last}, 32'h66);
    rd(4'd3, 1'b0);                                 // R7 word 3 unchanged

    for (int i = 0; i < 10; i++) bit_cycle(1'b1);   // R8 clocks while deselected
    chk("R8 no request while deselected", 32'(req_cnt), 32'd2);
    frame({60'h0, 4'b0110}, 4);                     // R8 aborted instruction
    chk("R8 no request on abort", 32'(req_cnt), 32'd2);
    rd(4'd3, 1'b1);
    rd(4'd7, 1'b1);

    wclk(20);
    chk("R3 all expected words seen", 32'(expq.size()), 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule